// File: doc/BRIEF.md
# Receive Statistics Counter Bank

This block keeps the receive statistics of one Ethernet port. Each time the receive path finishes a frame, it presents a single-cycle completion event. The event carries the frame's byte length and a set of status flags: bad CRC, alignment error, symbol error, multicast, broadcast, pause and MAC control. The block sorts the frame into a length class and a set of error and type categories, and it bumps every counter that matches. It also adds the frame length into two byte totals. Separately, it counts entries into the receive low-power-idle (LPI) state and the number of clock cycles spent in that state.

Software reads the counters through a simple port. A read returns the value and clears that counter in the same operation. Every counter stops at all-ones instead of wrapping. If an increment arrives on the same cycle that the counter is read and cleared, the increment is kept. The upper frame-length limit is a writable register, and the length classes are measured against it.

Top module: `rxstat_bank`

## Requirements
- R1: A frame with 64 <= length <= max length increments exactly one length-bin counter: address 1 (exactly 64), 2 (65..127), 3 (128..255), 4 (256..511), 5 (512..1023) or 6 (1024..max length).
- R2: A frame shorter than 64 bytes increments address 0 (undersize) when its CRC is good, or address 13 (fragment) when its CRC is bad.
- R3: A frame longer than max length increments address 7 (oversize) when its CRC is good, or address 14 (jabber) when its CRC is bad.
- R4: A frame is good when its length is in 64..max and it has no CRC, alignment or symbol error. Good frames increment address 8. An in-range frame with a bad CRC increments address 9.
- R5: The multicast (10), broadcast (11), pause (12) and control (19) counters increment only for good frames that carry the matching flag.
- R6: Any frame with the alignment flag increments address 15. Any frame with the symbol flag increments address 18.
- R7: Address 16 accumulates the length of every frame. Address 17 accumulates the length of good frames only.
- R8: Address 20 counts `lpi_enter` pulses. Address 21 counts the clock cycles in which `lpi_state` is high.
- R9: Every counter saturates at all-ones and never wraps.
- R10: When `rd_en` is high, `rd_data` shows the addressed value one cycle later and that counter is cleared. Address 22 returns the max length and clears nothing. Addresses 23 and above read as zero.
- R11: An increment on the same cycle as the read of that counter is retained: afterwards the counter equals that increment.
- R12: The max length resets to 1518 and is replaced by `cfg_max_len` when `cfg_wr_en` is high.
- R13: After reset every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Frame-complete event, one cycle per frame |
| evt_len | input | LEN_W | Frame length in bytes |
| evt_crc_err | input | 1 | Frame failed its CRC check |
| evt_align_err | input | 1 | Frame had an alignment error |
| evt_sym_err | input | 1 | Frame contained a symbol error |
| evt_mcast | input | 1 | Multicast destination |
| evt_bcast | input | 1 | Broadcast destination |
| evt_pause | input | 1 | Pause frame |
| evt_ctrl | input | 1 | MAC control frame |
| lpi_enter | input | 1 | One-cycle pulse on entry to receive LPI |
| lpi_state | input | 1 | High while the receiver is in LPI |
| cfg_wr_en | input | 1 | Load a new max length |
| cfg_max_len | input | LEN_W | New max length value |
| rd_en | input | 1 | Read-and-clear request |
| rd_addr | input | 5 | Address to read |
| rd_data | output | CNT_W | Read result, valid one cycle after `rd_en` |

## Verification
The embedded properties assume two things about the inputs. First, the status flags matter only in a cycle where `evt_valid` is high. Second, a read never targets a counter whose value is needed for a later check in the same window. The properties also assume that `LEN_W` does not exceed `CNT_W`, so that a single increment can never be larger than the counter.

The bench drives each event for exactly one cycle. It drains every counter between scenarios, so each check starts from zero. The only read that overlaps an increment is the one scenario built for that purpose. Saturation is reached by running a narrowed 16-bit counter instance long enough, with the LPI level held high and with a series of long frames.

// File: rtl/rxstat_pkg.sv
// Package: shared address map and fixed constants for the receive
// statistics bank. Assumes counter addresses are dense from zero.
package rxstat_pkg;
    localparam int ADDR_W      = 5;
    localparam int NUM_CNT     = 22;
    localparam int NUM_BINS    = 6;
    localparam int MIN_FRAME   = 64;

    localparam int A_UNDER     = 0;
    localparam int A_BIN0      = 1;   // bins occupy A_BIN0 .. A_BIN0+NUM_BINS-1
    localparam int A_OVER      = 7;
    localparam int A_GOOD      = 8;
    localparam int A_CRC       = 9;
    localparam int A_MCAST     = 10;
    localparam int A_BCAST     = 11;
    localparam int A_PAUSE     = 12;
    localparam int A_FRAG      = 13;
    localparam int A_JABBER    = 14;
    localparam int A_ALIGN     = 15;
    localparam int A_BYTES_ALL = 16;
    localparam int A_BYTES_OK  = 17;
    localparam int A_SYMBOL    = 18;
    localparam int A_CTRL      = 19;
    localparam int A_LPI_CNT   = 20;
    localparam int A_LPI_TIME  = 21;
    localparam int A_MAXLEN    = 22;
endpackage

// File: rtl/rxstat_classify.sv
// Module: rxstat_classify
// Turns one frame-complete event plus the LPI inputs into a vector of
// per-counter increment enables. Purely combinational apart from the
// clock used by its assertions. Assumes flags are meaningful only with
// evt_valid, and max_len >= 64.
module rxstat_classify
    import rxstat_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [LEN_W-1:0] evt_len,
    input  logic             evt_crc_err,
    input  logic             evt_align_err,
    input  logic             evt_sym_err,
    input  logic             evt_mcast,
    input  logic             evt_bcast,
    input  logic             evt_pause,
    input  logic             evt_ctrl,
    input  logic             lpi_enter,
    input  logic             lpi_state,
    input  logic [LEN_W-1:0] max_len,
    output logic [NUM_CNT-1:0] inc_vec
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);

    logic is_short, is_long, in_range, is_good;
    logic [NUM_BINS-1:0] bin_hit;

    // Purpose: decide the size class of the frame against the limits.
    always_comb begin
        is_short = evt_len < MIN_L;
        is_long  = evt_len > max_len;
        in_range = !is_short && !is_long;
        is_good  = in_range && !evt_crc_err && !evt_align_err && !evt_sym_err;
    end

    // Bin k spans [lo_k, hi_k]; bin 0 is exactly 64, the last bin ends at max_len.
    for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
        localparam int LO_I = (k == 0) ? MIN_FRAME :
                              (k == 1) ? MIN_FRAME + 1 : (MIN_FRAME << (k - 1));
        localparam int HI_I = (k == 0) ? MIN_FRAME : (MIN_FRAME << k) - 1;
        localparam logic [LEN_W-1:0] LO = LEN_W'(LO_I);
        localparam logic [LEN_W-1:0] HI = LEN_W'(HI_I);
        if (k == NUM_BINS - 1) begin : g_last
            // Purpose: top bin is bounded by the configured maximum.
            always_comb bin_hit[k] = in_range && (evt_len >= LO);
        end else begin : g_mid
            // Purpose: fixed-width bin test, still limited by max_len.
            always_comb bin_hit[k] = in_range && (evt_len >= LO) && (evt_len <= HI);
        end
    end

    // Purpose: map classes and flags onto counter addresses.
    always_comb begin
        inc_vec = '0;
        inc_vec[A_UNDER]     = evt_valid && is_short && !evt_crc_err;
        inc_vec[A_FRAG]      = evt_valid && is_short &&  evt_crc_err;
        inc_vec[A_OVER]      = evt_valid && is_long  && !evt_crc_err;
        inc_vec[A_JABBER]    = evt_valid && is_long  &&  evt_crc_err;
        for (int k = 0; k < NUM_BINS; k++)
            inc_vec[A_BIN0 + k] = evt_valid && bin_hit[k];
        inc_vec[A_GOOD]      = evt_valid && is_good;
        inc_vec[A_CRC]       = evt_valid && in_range && evt_crc_err;
        inc_vec[A_MCAST]     = evt_valid && is_good && evt_mcast;
        inc_vec[A_BCAST]     = evt_valid && is_good && evt_bcast;
        inc_vec[A_PAUSE]     = evt_valid && is_good && evt_pause;
        inc_vec[A_CTRL]      = evt_valid && is_good && evt_ctrl;
        inc_vec[A_ALIGN]     = evt_valid && evt_align_err;
        inc_vec[A_SYMBOL]    = evt_valid && evt_sym_err;
        inc_vec[A_BYTES_ALL] = evt_valid;
        inc_vec[A_BYTES_OK]  = evt_valid && is_good;
        inc_vec[A_LPI_CNT]   = lpi_enter;
        inc_vec[A_LPI_TIME]  = lpi_state;
    end

    AST_ONE_SIZE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $onehot({inc_vec[A_UNDER], inc_vec[A_FRAG], inc_vec[A_OVER],
                               inc_vec[A_JABBER], inc_vec[A_BIN0 +: NUM_BINS]})); // R1
    AST_GOOD_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        inc_vec[A_GOOD] |-> (!evt_crc_err && !evt_align_err && !evt_sym_err
                             && evt_len >= MIN_L && evt_len <= max_len)); // R4
    AST_TYPE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_vec[A_MCAST] || inc_vec[A_BCAST] || inc_vec[A_PAUSE] || inc_vec[A_CTRL])
        |-> inc_vec[A_GOOD]); // R5
    AST_SHORT_LONG_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_vec[A_FRAG] || inc_vec[A_JABBER]) |-> evt_crc_err); // R2
endmodule

// File: rtl/rxstat_sat_cnt.sv
// Module: rxstat_sat_cnt
// One saturating counter with clear-on-read. The clear and an increment
// may coincide; the increment then lands on the cleared value. Assumes
// INC_W <= CNT_W so a single increment fits.
module rxstat_sat_cnt #(
    parameter int CNT_W = 32,
    parameter int INC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc_amt,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] step;
    logic [CNT_W:0]   sum;

    // Purpose: saturating add of the increment onto the (possibly cleared) value.
    always_comb begin
        base = clr ? '0 : cnt;
        step = inc_en ? CNT_W'(inc_amt) : '0;
        sum  = {1'b0, base} + {1'b0, step};
    end

    // Purpose: register the count, clamping at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (sum[CNT_W])  cnt <= ALL_ONES;
        else                  cnt <= sum[CNT_W-1:0];
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == ALL_ONES && !clr) |=> cnt == ALL_ONES); // R9
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt)); // R9
    AST_CLR_KEEPS_INC: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == ($past(inc_en) ? CNT_W'($past(inc_amt)) : '0)); // R11
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc_en) |=> $stable(cnt)); // R10
endmodule

// File: rtl/rxstat_bank.sv
// Module: rxstat_bank (top)
// Receive statistics bank for one port: classifies frame events, holds
// one saturating counter per statistic, a writable max-length register
// and a registered read-and-clear port. Assumes LEN_W <= CNT_W.
module rxstat_bank
    import rxstat_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int LEN_W       = 16,
    parameter int DEF_MAX_LEN = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [LEN_W-1:0]  evt_len,
    input  logic              evt_crc_err,
    input  logic              evt_align_err,
    input  logic              evt_sym_err,
    input  logic              evt_mcast,
    input  logic              evt_bcast,
    input  logic              evt_pause,
    input  logic              evt_ctrl,
    input  logic              lpi_enter,
    input  logic              lpi_state,
    input  logic              cfg_wr_en,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);
    logic [LEN_W-1:0]   max_len;
    logic [NUM_CNT-1:0] inc_vec;
    logic [NUM_CNT-1:0] clr_vec;
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];
    logic [CNT_W-1:0]   rd_mux;

    // Purpose: hold the configurable upper frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)         max_len <= LEN_W'(DEF_MAX_LEN);
        else if (cfg_wr_en) max_len <= cfg_max_len;
    end

    rxstat_classify #(.LEN_W(LEN_W)) u_class (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_valid     (evt_valid),
        .evt_len       (evt_len),
        .evt_crc_err   (evt_crc_err),
        .evt_align_err (evt_align_err),
        .evt_sym_err   (evt_sym_err),
        .evt_mcast     (evt_mcast),
        .evt_bcast     (evt_bcast),
        .evt_pause     (evt_pause),
        .evt_ctrl      (evt_ctrl),
        .lpi_enter     (lpi_enter),
        .lpi_state     (lpi_state),
        .max_len       (max_len),
        .inc_vec       (inc_vec)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam bit IS_BYTES = (i == A_BYTES_ALL) || (i == A_BYTES_OK);
        logic [LEN_W-1:0] amt;
        // Purpose: byte totals add the length, all others add one.
        always_comb amt = IS_BYTES ? evt_len : LEN_W'(1);
        // Purpose: clear this counter when it is the read target.
        always_comb clr_vec[i] = rd_en && (rd_addr == ADDR_W'(i));

        rxstat_sat_cnt #(.CNT_W(CNT_W), .INC_W(LEN_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_en  (inc_vec[i]),
            .inc_amt (amt),
            .clr     (clr_vec[i]),
            .cnt     (cnt_q[i])
        );
    end

    // Purpose: select the addressed counter or the max-length register.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CNT; i++)
            if (rd_addr == ADDR_W'(i)) rd_mux = cnt_q[i];
        if (rd_addr == ADDR_W'(A_MAXLEN)) rd_mux = CNT_W'(max_len);
    end

    // Purpose: register the read result, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    AST_MAXLEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> max_len == $past(cfg_max_len)); // R12
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R10
    AST_CLR_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_vec)); // R10
endmodule

// File: tb/rxstat_bank_test.sv
`timescale 1ns/1ps
module rxstat_bank_test;
    localparam int CW = 16;
    localparam int LW = 16;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          evt_valid = 0;
    logic [LW-1:0] evt_len = '0;
    logic          evt_crc_err = 0, evt_align_err = 0, evt_sym_err = 0;
    logic          evt_mcast = 0, evt_bcast = 0, evt_pause = 0, evt_ctrl = 0;
    logic          lpi_enter = 0, lpi_state = 0;
    logic          cfg_wr_en = 0;
    logic [LW-1:0] cfg_max_len = '0;
    logic          rd_en = 0;
    logic [4:0]    rd_addr = '0;
    logic [CW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    rxstat_bank #(.CNT_W(CW), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_len(evt_len),
        .evt_crc_err(evt_crc_err), .evt_align_err(evt_align_err),
        .evt_sym_err(evt_sym_err), .evt_mcast(evt_mcast), .evt_bcast(evt_bcast),
        .evt_pause(evt_pause), .evt_ctrl(evt_ctrl), .lpi_enter(lpi_enter),
        .lpi_state(lpi_state), .cfg_wr_en(cfg_wr_en), .cfg_max_len(cfg_max_len),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic rd(input int addr, output int val);
        @(negedge clk);
        rd_en = 1; rd_addr = 5'(addr);
        @(negedge clk);
        rd_en = 0;
        val = int'(rd_data);
    endtask

    task automatic rd_chk(input string req, input int addr, input int exp);
        int v;
        rd(addr, v);
        chk(req, v, exp);
    endtask

    task automatic drain_all();
        int v;
        for (int i = 0; i < 22; i++) rd(i, v);
    endtask

    task automatic frame(input int len, input bit crc, input bit al, input bit sy,
                         input bit mc, input bit bc, input bit pa, input bit ct);
        @(negedge clk);
        evt_valid = 1; evt_len = LW'(len);
        evt_crc_err = crc; evt_align_err = al; evt_sym_err = sy;
        evt_mcast = mc; evt_bcast = bc; evt_pause = pa; evt_ctrl = ct;
        @(negedge clk);
        evt_valid = 0; evt_crc_err = 0; evt_align_err = 0; evt_sym_err = 0;
        evt_mcast = 0; evt_bcast = 0; evt_pause = 0; evt_ctrl = 0;
    endtask

    // R13 / R12: reset state of all counters and the max length
    task automatic t_reset();
        for (int i = 0; i < 22; i++) rd_chk("R13 counter zero after reset", i, 0);
        rd_chk("R12 default max length", 22, 1518);
    endtask

    // R1 / R4 / R7: good frames across every bin edge
    task automatic t_bins();
        int lens[11] = '{64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518};
        foreach (lens[i]) frame(lens[i], 0, 0, 0, 0, 0, 0, 0);
        rd_chk("R1 bin 64", 1, 1);
        rd_chk("R1 bin 65..127", 2, 2);
        rd_chk("R1 bin 128..255", 3, 2);
        rd_chk("R1 bin 256..511", 4, 2);
        rd_chk("R1 bin 512..1023", 5, 2);
        rd_chk("R1 bin 1024..max", 6, 2);
        rd_chk("R4 good count", 8, 11);
        rd_chk("R7 bytes all", 16, 5483);
        rd_chk("R7 bytes good", 17, 5483);
        rd_chk("R2 no undersize", 0, 0);
        drain_all();
    endtask

    // R2 / R3 / R4 / R7: short and long frames with good and bad CRC
    task automatic t_short_long();
        frame(63, 0, 0, 0, 0, 0, 0, 0);
        frame(10, 1, 0, 0, 0, 0, 0, 0);
        frame(1519, 0, 0, 0, 0, 0, 0, 0);
        frame(2000, 1, 0, 0, 0, 0, 0, 0);
        frame(100, 1, 0, 0, 0, 0, 0, 0);
        rd_chk("R2 undersize", 0, 1);
        rd_chk("R2 fragment", 13, 1);
        rd_chk("R3 oversize", 7, 1);
        rd_chk("R3 jabber", 14, 1);
        rd_chk("R4 crc in range", 9, 1);
        rd_chk("R4 no good frames", 8, 0);
        rd_chk("R7 bytes all", 16, 3692);
        rd_chk("R7 bytes good", 17, 0);
        drain_all();
    endtask

    // R5 / R6: type flags only on good frames, error flags always
    task automatic t_flags();
        frame(100, 0, 0, 0, 1, 0, 0, 0);
        frame(100, 0, 0, 0, 0, 1, 0, 0);
        frame(64,  0, 0, 0, 0, 0, 1, 1);
        frame(100, 1, 0, 0, 1, 0, 0, 0);
        frame(100, 0, 1, 0, 0, 1, 0, 0);
        frame(100, 0, 0, 1, 0, 0, 1, 1);
        rd_chk("R5 multicast good only", 10, 1);
        rd_chk("R5 broadcast good only", 11, 1);
        rd_chk("R5 pause good only", 12, 1);
        rd_chk("R5 control good only", 19, 1);
        rd_chk("R6 alignment", 15, 1);
        rd_chk("R6 symbol", 18, 1);
        rd_chk("R4 good count", 8, 3);
        rd_chk("R7 bytes good", 17, 264);
        drain_all();
    endtask

    // R12 / R3 / R1: reprogrammed maximum length
    task automatic t_maxlen();
        @(negedge clk);
        cfg_wr_en = 1; cfg_max_len = LW'(1000);
        @(negedge clk);
        cfg_wr_en = 0;
        frame(1001, 0, 0, 0, 0, 0, 0, 0);
        frame(1000, 0, 0, 0, 0, 0, 0, 0);
        rd_chk("R3 oversize vs new max", 7, 1);
        rd_chk("R1 bin 512..1023 at new max", 5, 1);
        rd_chk("R12 max length readback", 22, 1000);
        rd_chk("R10 max length read does not clear", 22, 1000);
        @(negedge clk);
        cfg_wr_en = 1; cfg_max_len = LW'(1518);
        @(negedge clk);
        cfg_wr_en = 0;
        drain_all();
    endtask

    // R8: LPI entries and time
    task automatic t_lpi();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); lpi_enter = 1;
            @(negedge clk); lpi_enter = 0;
        end
        @(negedge clk); lpi_state = 1;
        repeat (5) @(negedge clk);
        lpi_state = 0;
        rd_chk("R8 lpi entries", 20, 3);
        rd_chk("R8 lpi time", 21, 5);
        rd_chk("R10 clear on read", 21, 0);
    endtask

    // R11: read and increment of the same counter in one cycle
    task automatic t_rd_inc();
        @(negedge clk);
        evt_valid = 1; evt_len = LW'(100);
        rd_en = 1; rd_addr = 5'd8;
        @(negedge clk);
        evt_valid = 0; rd_en = 0;
        chk("R11 read returns old value", int'(rd_data), 0);
        rd_chk("R11 increment retained", 8, 1);
        drain_all();
    endtask

    // R9 / R10: saturation and unused address
    task automatic t_sat();
        @(negedge clk); lpi_state = 1;
        repeat (70000) @(negedge clk);
        lpi_state = 0;
        rd_chk("R9 lpi time saturates", 21, 65535);
        for (int i = 0; i < 44; i++) frame(1500, 0, 0, 0, 0, 0, 0, 0);
        rd_chk("R9 bytes all saturates", 16, 65535);
        rd_chk("R9 bytes good saturates", 17, 65535);
        rd_chk("R10 unused address reads zero", 30, 0);
        drain_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_bins();
        t_short_long();
        t_flags();
        t_maxlen();
        t_lpi();
        t_rd_inc();
        t_sat();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule